// File: doc/BRIEF.md
# Integer Narrowing Shift-Round-Saturate Unit

This unit narrows one integer scalar taken from a wide accumulator lane into a smaller output lane. The accumulator element is 16 or 32 bits wide and the output lane is 8 or 16 bits wide. The element is first widened to the internal 64-bit width, either with sign extension or with zero extension. It is then shifted right arithmetically by 0 to 31 places. Rounding is optional: when it is on, half of the shift weight is added before the shift. Last, the value is clamped to the output range, or the unit keeps only the low output bits.

Two flags shape the result independently. One says whether the input is signed. The other says whether the output range is signed. An unsigned input is clamped against the upper bound only. When the narrowing controls are off (equal-width operation), the unit passes the low output-width bits of the input straight through.

The unit processes one element per clock. The result is registered, and a valid flag travels with the data.

Top module: `nrw_lane_top`

## Requirements
- R1: `out_valid` is asserted exactly one clock after a cycle with `in_valid` high, and is low otherwise. A synchronous reset clears `out_valid` and `out_value` to zero.
- R2: When `narrow_en` is 0, `out_value` equals the low 16 bits of `in_value` if `out_wide`=1, or the low 8 bits zero-extended if `out_wide`=0. The shift, rounding and clamp controls have no effect in this case.
- R3: The accumulator width is 32 bits when `z_wide`=1 and 16 bits when `z_wide`=0. Input bits above that width are ignored. With `z_signed`=1 the element is sign-extended from its top bit; with `z_signed`=0 it is zero-extended.
- R4: The extended value is shifted right arithmetically by `shamt` (0 to 31) at 64-bit width.
- R5: When `round_en`=1 and `shamt` is nonzero, 2^(`shamt`-1) is added before the shift. With `shamt`=0, rounding has no effect.
- R6: When `sat_en`=0, the output is the low output-width bits of the shifted value.
- R7: When `sat_en`=1, `z_signed`=1 and `sat_signed`=1, the shifted value is clamped to [-2^(W-1), 2^(W-1)-1], where W is the output width. The result is given in two's complement over W bits.
- R8: When `sat_en`=1, `z_signed`=1 and `sat_signed`=0, the shifted value is clamped to [0, 2^W-1].
- R9: When `sat_en`=1 and `z_signed`=0, the only clamp is an upper bound compared as unsigned. Values at or above hi become hi-1, where hi is 2^W, or 2^(W-1) when `sat_signed`=1.
- R10: The output width W is 16 when `out_wide`=1 and 8 when `out_wide`=0. In 8-bit mode, `out_value[15:8]` is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input element valid |
| in_value | input | 64 | Accumulator element (low 16 or 32 bits used) |
| narrow_en | input | 1 | 1 = apply narrowing controls, 0 = pass-through |
| z_wide | input | 1 | Accumulator width: 1 = 32 bits, 0 = 16 bits |
| out_wide | input | 1 | Output width: 1 = 16 bits, 0 = 8 bits |
| shamt | input | 5 | Right shift amount |
| z_signed | input | 1 | Input is signed |
| sat_signed | input | 1 | Clamp range is signed |
| sat_en | input | 1 | 1 = clamp, 0 = truncate |
| round_en | input | 1 | Round half up before shifting |
| out_valid | output | 1 | Result valid |
| out_value | output | 16 | Narrowed result, zero-extended in 8-bit mode |

## Verification
Directed vectors come first.
- They pair each element with the same value under the opposite signedness, to tell sign extension apart from zero extension.
- They repeat a shift with and without rounding at the halfway point, and again at zero shift.
- They drive values just past each bound under all three clamp combinations. This separates the signed, unsigned-range and upper-only clamps.

Pass-through vectors carry nonzero shift and clamp flags, so that any leak of the narrowing path into equal-width mode shows up. Several hundred random vectors then cover every control combination against an independent reference model. Back-to-back issue is mixed with idle gaps to expose valid-timing errors.

// File: rtl/nrw_pkg.sv
package nrw_pkg;
  localparam int SH_W = 5;

  typedef struct packed {
    logic            narrow_en;
    logic            z_wide;
    logic            out_wide;
    logic [SH_W-1:0] shamt;
    logic            z_signed;
    logic            sat_signed;
    logic            sat_en;
    logic            round_en;
  } nrw_ctrl_t;
endpackage

// File: rtl/nrw_extend.sv
module nrw_extend #(
  parameter int IN_W = 64,
  parameter int ZN_W = 16,
  parameter int ZW_W = 32
) (
  input  logic [IN_W-1:0] din,
  input  logic            z_wide,
  input  logic            z_signed,
  output logic [IN_W-1:0] dout
);
  logic fill;
  int   elem_w;

  always_comb begin
    elem_w = z_wide ? ZW_W : ZN_W;
    fill   = z_signed & (z_wide ? din[ZW_W-1] : din[ZN_W-1]);
    for (int i = 0; i < IN_W; i++) begin
      dout[i] = (i < elem_w) ? din[i] : fill;
    end
  end
endmodule

// File: rtl/nrw_round_shift.sv
module nrw_round_shift #(
  parameter int ACC_W = 64,
  parameter int SH_W  = 5
) (
  input  logic [ACC_W-1:0] val_i,
  input  logic [SH_W-1:0]  shamt,
  input  logic             round_en,
  output logic [ACC_W-1:0] val_o
);
  logic [ACC_W-1:0] bias;
  logic [ACC_W-1:0] sum;

  always_comb begin
    if (round_en && (shamt != '0))
      bias = ACC_W'(1) << (shamt - SH_W'(1));
    else
      bias = '0;
    sum   = val_i + bias;
    val_o = $signed(sum) >>> shamt;
  end
endmodule

// File: rtl/nrw_clamp.sv
module nrw_clamp #(
  parameter int ACC_W = 64,
  parameter int ON_W  = 8,
  parameter int OW_W  = 16
) (
  input  logic [ACC_W-1:0] val_i,
  input  logic             out_wide,
  input  logic             z_signed,
  input  logic             sat_signed,
  input  logic             sat_en,
  output logic [OW_W-1:0]  res_o
);
  localparam int WB_W = $clog2(OW_W) + 1;

  logic [WB_W-1:0]         bound_w;
  logic signed [ACC_W-1:0] hi, lo, v, sat_v;

  always_comb begin
    bound_w = out_wide ? WB_W'(OW_W) : WB_W'(ON_W);
    if (sat_signed) bound_w = bound_w - WB_W'(1);
    hi    = ACC_W'(1) << bound_w;
    lo    = (z_signed && sat_signed) ? -hi : '0;
    v     = $signed(val_i);
    sat_v = v;
    if (sat_en) begin
      if (z_signed) begin
        if (v < lo)       sat_v = lo;
        else if (v >= hi) sat_v = hi - ACC_W'(1);
      end else if ($unsigned(v) >= $unsigned(hi)) begin
        sat_v = hi - ACC_W'(1);
      end
    end
    res_o = out_wide ? sat_v[OW_W-1:0] : OW_W'(sat_v[ON_W-1:0]);
  end
endmodule

// File: rtl/nrw_lane_top.sv
module nrw_lane_top #(
  parameter int IN_W     = 64,
  parameter int ZN_W     = 16,
  parameter int ZW_W     = 32,
  parameter int NARROW_W = 8,
  parameter int WIDE_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [IN_W-1:0]          in_value,
  input  logic                     narrow_en,
  input  logic                     z_wide,
  input  logic                     out_wide,
  input  logic [nrw_pkg::SH_W-1:0] shamt,
  input  logic                     z_signed,
  input  logic                     sat_signed,
  input  logic                     sat_en,
  input  logic                     round_en,
  output logic                     out_valid,
  output logic [WIDE_W-1:0]        out_value
);
  import nrw_pkg::*;

  nrw_ctrl_t        ctrl;
  logic [IN_W-1:0]  ext_v;
  logic [IN_W-1:0]  shr_v;
  logic [WIDE_W-1:0] clamp_v;
  logic [WIDE_W-1:0] pass_v;
  logic [WIDE_W-1:0] next_v;

  assign ctrl = '{narrow_en: narrow_en, z_wide: z_wide, out_wide: out_wide,
                  shamt: shamt, z_signed: z_signed, sat_signed: sat_signed,
                  sat_en: sat_en, round_en: round_en};

  nrw_extend #(.IN_W(IN_W), .ZN_W(ZN_W), .ZW_W(ZW_W)) u_ext (
    .din(in_value), .z_wide(ctrl.z_wide), .z_signed(ctrl.z_signed), .dout(ext_v)
  );

  nrw_round_shift #(.ACC_W(IN_W), .SH_W(SH_W)) u_shr (
    .val_i(ext_v), .shamt(ctrl.shamt), .round_en(ctrl.round_en), .val_o(shr_v)
  );

  nrw_clamp #(.ACC_W(IN_W), .ON_W(NARROW_W), .OW_W(WIDE_W)) u_clamp (
    .val_i(shr_v), .out_wide(ctrl.out_wide), .z_signed(ctrl.z_signed),
    .sat_signed(ctrl.sat_signed), .sat_en(ctrl.sat_en), .res_o(clamp_v)
  );

  assign pass_v = ctrl.out_wide ? in_value[WIDE_W-1:0] : WIDE_W'(in_value[NARROW_W-1:0]);
  assign next_v = ctrl.narrow_en ? clamp_v : pass_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_value <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_value <= next_v;
    end
  end

  // R1
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid)) |-> out_valid);

  // R2
  pass_thru_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !narrow_en && out_wide) |=> (out_value == $past(in_value[WIDE_W-1:0])));

  // R10
  narrow_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !out_wide) |=> (out_value[WIDE_W-1:NARROW_W] == '0));

  // R8
  neg_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && narrow_en && sat_en && z_signed && !sat_signed && !round_en &&
     (z_wide ? in_value[ZW_W-1] : in_value[ZN_W-1])) |=> (out_value == '0));

  // R9
  uns_top_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && narrow_en && sat_en && !z_signed && sat_signed && !out_wide)
      |=> (out_value[NARROW_W-1] == 1'b0));
endmodule

// File: tb/nrw_lane_top_tb_top.sv
module nrw_lane_top_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [63:0] in_value;
  logic        narrow_en, z_wide, out_wide, z_signed, sat_signed, sat_en, round_en;
  logic [4:0]  shamt;
  logic        out_valid;
  logic [15:0] out_value;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  typedef struct {
    logic [15:0] exp;
    int          due;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nrw_lane_top dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_value(in_value),
    .narrow_en(narrow_en), .z_wide(z_wide), .out_wide(out_wide), .shamt(shamt),
    .z_signed(z_signed), .sat_signed(sat_signed), .sat_en(sat_en),
    .round_en(round_en), .out_valid(out_valid), .out_value(out_value)
  );

  function automatic logic [15:0] model(logic ne, logic zw, logic ow, logic [4:0] sh,
                                        logic zs, logic ss, logic se, logic re,
                                        logic [63:0] d);
    longint v;
    longint hi;
    longint lo;
    int     wb;
    if (!ne) return ow ? d[15:0] : {8'h00, d[7:0]};
    if (zs) v = zw ? longint'($signed(d[31:0])) : longint'($signed(d[15:0]));
    else    v = zw ? longint'({32'h0, d[31:0]}) : longint'({48'h0, d[15:0]});
    if (re && sh != 0) v = v + (longint'(1) <<< (sh - 1));
    v = v >>> sh;
    if (se) begin
      wb = (ow ? 16 : 8) - (ss ? 1 : 0);
      hi = longint'(1) <<< wb;
      if (zs) begin
        lo = ss ? -hi : 0;
        if (v < lo) v = lo;
        if (v >= hi) v = hi - 1;
      end else if (unsigned'(v) >= unsigned'(hi)) begin
        v = hi - 1;
      end
    end
    return ow ? v[15:0] : {8'h00, v[7:0]};
  endfunction

  task automatic apply(string tag, logic ne, logic zw, logic ow, logic [4:0] sh,
                       logic zs, logic ss, logic se, logic re, logic [63:0] d);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1; in_value = d; narrow_en = ne; z_wide = zw; out_wide = ow;
    shamt = sh; z_signed = zs; sat_signed = ss; sat_en = se; round_en = re;
    it.exp = model(ne, zw, ow, sh, zs, ss, se, re, d);
    it.due = cyc + 1;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: compare at the falling edge when each item is due
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (sb_q.size() != 0 && sb_q[0].due == cyc) begin
        checks++;
        if (!out_valid || out_value != sb_q[0].exp) begin
          fails++;
          $display("FAIL %s: out_valid=%0b out_value=%h expected valid=1 value=%h",
                   sb_q[0].tag, out_valid, out_value, sb_q[0].exp);
        end
        void'(sb_q.pop_front());
      end else if (out_valid) begin
        checks++;
        fails++;
        $display("FAIL R1: out_valid=1 expected 0 at cycle %0d", cyc);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: run incomplete, expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_value = '0; narrow_en = 0; z_wide = 0;
    out_wide = 0; shamt = 0; z_signed = 0; sat_signed = 0; sat_en = 0; round_en = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    checks++;
    if (out_valid !== 1'b0 || out_value !== 16'h0) begin
      fails++;
      $display("FAIL R1 reset: valid=%0b value=%h expected 0 0000", out_valid, out_value);
    end
    rst = 1'b0;

    // R2 pass-through with narrowing controls set
    apply("R2 wide",   0, 1, 1, 5'd7, 1, 1, 1, 1, 64'h1234_5678_9ABC_DEF0);
    apply("R2 narrow", 0, 0, 0, 5'd3, 1, 0, 1, 0, 64'h1234_5678_9ABC_DEF0);
    // R3 extension and ignored upper bits
    apply("R3 signed16",   1, 0, 1, 5'd4, 1, 0, 0, 0, 64'hFFFF_FFFF_0000_8000);
    apply("R3 unsigned16", 1, 0, 1, 5'd4, 0, 0, 0, 0, 64'hFFFF_FFFF_0000_8000);
    apply("R3 signed32",   1, 1, 1, 5'd16, 1, 0, 0, 0, 64'h0000_0000_8001_0000);
    // R4 shift extremes
    apply("R4 sh31", 1, 1, 1, 5'd31, 1, 0, 0, 0, 64'h0000_0000_8000_0000);
    apply("R4 sh0",  1, 1, 1, 5'd0,  0, 0, 0, 0, 64'h0000_0000_0000_BEEF);
    // R5 rounding
    apply("R5 round",    1, 1, 1, 5'd4, 0, 0, 0, 1, 64'h18);
    apply("R5 noround",  1, 1, 1, 5'd4, 0, 0, 0, 0, 64'h18);
    apply("R5 sh0round", 1, 1, 1, 5'd0, 0, 0, 0, 1, 64'h7);
    apply("R5 negative", 1, 0, 1, 5'd1, 1, 0, 0, 1, 64'hFFFD);
    idle(3);
    // R6 truncation
    apply("R6 trunc8", 1, 1, 0, 5'd0, 0, 0, 0, 0, 64'h0001_2345);
    // R7 signed clamp
    apply("R7 hi8", 1, 1, 0, 5'd0, 1, 1, 1, 0, 64'h0000_0200);
    apply("R7 lo8", 1, 1, 0, 5'd0, 1, 1, 1, 0, 64'hFFFF_FE00);
    apply("R7 hi16", 1, 1, 1, 5'd0, 1, 1, 1, 0, 64'h0001_0000);
    // R8 signed input, unsigned range
    apply("R8 neg", 1, 1, 0, 5'd2, 1, 0, 1, 0, 64'hFFFF_FF00);
    apply("R8 hi",  1, 1, 0, 5'd0, 1, 0, 1, 0, 64'h0000_0300);
    // R9 unsigned input, upper clamp only
    apply("R9 uns16", 1, 1, 1, 5'd0, 0, 0, 1, 0, 64'hFFFF_FFFF);
    apply("R9 ss16",  1, 1, 1, 5'd0, 0, 1, 1, 0, 64'hFFFF_FFFF);
    apply("R9 ss8edge", 1, 0, 0, 5'd0, 0, 1, 1, 0, 64'h0080);
    // R10 width select
    apply("R10 w8", 1, 0, 0, 5'd0, 1, 0, 0, 0, 64'hFFFF);
    idle(2);

    // random sweep over all controls
    for (int k = 0; k < 400; k++) begin
      logic [7:0] c;
      c = 8'($urandom);
      apply("R3-R10 random", c[0] | c[1], c[2], c[3], 5'($urandom), c[4], c[5], c[6], c[7],
            {$urandom, $urandom});
      if (k % 37 == 0) idle(1);
    end
    idle(4);

    done = 1;
    checks++;
    if (sb_q.size() != 0) begin
      fails++;
      $display("FAIL R1: %0d results missing, expected 0", sb_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule